// File: doc/BRIEF.md
# Adapter Setup-Mode Port Decoder

This block sits on the host I/O bus of a display adapter. It decodes the adapter's global enable port, its wake port and the motherboard enable port. It holds the adapter enable flag, the setup-mode flag, a 3-bit ROM page select, the display-on flag and the motherboard enable flag. It claims the I/O cycles it answers, returns read data, and drives a response gate that tells the rest of the adapter's register file whether it may answer at all.

Setup mode silences the adapter. While setup mode is set, only the global enable port and the wake port respond, and the gate output is low. The global enable port answers at four 4 KB-spaced aliases. Its readback is allowed only while an external read-enable control bit, held in another register, is high.

Top module: `adapter_setup_decoder`

## Requirements
- R1: After a synchronous reset, setup_mode, adapter_en, rom_page, display_on and mb_en are all 0, io_claim is 0 and port_gate is 1.
- R2: A write to the global enable port stores write-data bits 2:0 as rom_page, bit 3 as adapter_en and bit 4 as setup_mode. Bits 7:5 are ignored. The port decodes when io_addr[11:0] is 6E8h and io_addr[15:12] is 4, 5, 6 or 7.
- R3: A claimed cycle raises io_claim for exactly the one cycle after the strobe, with io_rdata in that same cycle. A read of the global enable port is claimed only if rd_enable_ctl is 1, and it returns {3'b000, setup_mode, adapter_en, rom_page}. With rd_enable_ctl at 0 the read is not claimed and io_rdata is 0.
- R4: The wake port at 0102h responds only while setup_mode is 1. A write stores bit 0 as display_on, and a read returns {7'b0, display_on}. Outside setup mode its reads and writes are not claimed, and writes do not change display_on.
- R5: A write to port 03C3h stores bit 0 as mb_en and is claimed, but only while setup_mode is 0. In setup mode the write is ignored and not claimed. Reads of 03C3h are never claimed.
- R6: port_gate is 0 whenever setup_mode is 1. It changes in the same cycle as a write to the global enable port that changes bit 4, before the clock edge that stores that write.
- R7: Writes and reads of the global enable port are still accepted while setup_mode is 1, so that setup mode can be left.
- R8: Addresses outside the decoded set are never claimed. This includes 86E8h and 46E9h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_addr | input | 16 | Host I/O address |
| io_rd | input | 1 | Read strobe, one cycle per access |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_wdata | input | 8 | Write data |
| rd_enable_ctl | input | 1 | Allows readback of the global enable port |
| io_rdata | output | 8 | Read data, valid with io_claim |
| io_claim | output | 1 | Cycle claimed (registered) |
| adapter_en | output | 1 | Adapter enabled |
| setup_mode | output | 1 | Setup mode active |
| rom_page | output | 3 | ROM page select |
| display_on | output | 1 | Display function enabled by the wake port |
| mb_en | output | 1 | Motherboard enable flag |
| port_gate | output | 1 | High when the other adapter ports may respond |

## Verification
The bench targets four cases. It probes the upper aliases and near-miss addresses of the global enable port; a decoder that compares too few or too many address bits would miss an alias or claim 86E8h. It reads the wake port on both sides of setup mode, and writes the motherboard port while in setup; a design with a swapped qualifier would claim a silenced port or lose display_on. It samples port_gate between the write strobe and its clock edge, and a gate built from the stored flag would lag there by one cycle. Finally it reads the global enable port with its read-enable bit low, and a missing qualifier would claim that read.

// File: rtl/asd_pkg.sv
package asd_pkg;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 8;
  localparam int PAGE_W = 3;

  typedef struct packed {
    logic gen;
    logic wake;
    logic mb;
  } asd_hit_t;
endpackage

// File: rtl/asd_addr_decode.sv
module asd_addr_decode #(
  parameter int ADDR_W     = 16,
  parameter int LOW_W      = 12,
  parameter int GEN_LOW    = 12'h6E8,
  parameter int ALIAS_BASE = 4,
  parameter int NUM_ALIAS  = 4,
  parameter int WAKE_ADDR  = 16'h0102,
  parameter int MB_ADDR    = 16'h03C3
) (
  input  logic [ADDR_W-1:0] addr,
  output asd_pkg::asd_hit_t hit
);
  localparam int HI_W = ADDR_W - LOW_W;

  logic [NUM_ALIAS-1:0] alias_hit;

  for (genvar i = 0; i < NUM_ALIAS; i++) begin : g_alias
    assign alias_hit[i] = (addr[ADDR_W-1:LOW_W] == HI_W'(ALIAS_BASE + i));
  end

  always_comb begin
    hit.gen  = (addr[LOW_W-1:0] == LOW_W'(GEN_LOW)) && (|alias_hit);
    hit.wake = (addr == ADDR_W'(WAKE_ADDR));
    hit.mb   = (addr == ADDR_W'(MB_ADDR));
  end
endmodule

// File: rtl/asd_state_regs.sv
module asd_state_regs #(
  parameter int PAGE_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              gen_we,
  input  logic              wake_we,
  input  logic              mb_we,
  input  logic [PAGE_W+1:0] gen_wdata,
  input  logic              bit0,
  output logic [PAGE_W-1:0] rom_page,
  output logic              adapter_en,
  output logic              setup_mode,
  output logic              setup_next,
  output logic              display_on,
  output logic              mb_en
);
  localparam int EN_BIT    = PAGE_W;
  localparam int SETUP_BIT = PAGE_W + 1;

  always_comb begin
    setup_next = gen_we ? gen_wdata[SETUP_BIT] : setup_mode;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rom_page   <= '0;
      adapter_en <= 1'b0;
      setup_mode <= 1'b0;
      display_on <= 1'b0;
      mb_en      <= 1'b0;
    end else begin
      setup_mode <= setup_next;
      if (gen_we) begin
        rom_page   <= gen_wdata[PAGE_W-1:0];
        adapter_en <= gen_wdata[EN_BIT];
      end
      if (wake_we) display_on <= bit0;
      if (mb_we)   mb_en      <= bit0;
    end
  end
endmodule

// File: rtl/asd_response.sv
module asd_response #(
  parameter int DATA_W = 8,
  parameter int PAGE_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              claim_wr,
  input  logic              rd_gen,
  input  logic              rd_wake,
  input  logic [PAGE_W-1:0] rom_page,
  input  logic              adapter_en,
  input  logic              setup_mode,
  input  logic              display_on,
  output logic [DATA_W-1:0] io_rdata,
  output logic              io_claim
);
  logic [DATA_W-1:0] rdata_next;

  always_comb begin
    rdata_next = '0;
    if (rd_gen)
      rdata_next = DATA_W'({setup_mode, adapter_en, rom_page});
    else if (rd_wake)
      rdata_next = DATA_W'(display_on);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      io_claim <= 1'b0;
      io_rdata <= '0;
    end else begin
      io_claim <= claim_wr | rd_gen | rd_wake;
      io_rdata <= rdata_next;
    end
  end
endmodule

// File: rtl/adapter_setup_decoder.sv
module adapter_setup_decoder #(
  parameter int ADDR_W = asd_pkg::ADDR_W,
  parameter int DATA_W = asd_pkg::DATA_W,
  parameter int PAGE_W = asd_pkg::PAGE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_rd,
  input  logic              io_wr,
  input  logic [DATA_W-1:0] io_wdata,
  input  logic              rd_enable_ctl,
  output logic [DATA_W-1:0] io_rdata,
  output logic              io_claim,
  output logic              adapter_en,
  output logic              setup_mode,
  output logic [PAGE_W-1:0] rom_page,
  output logic              display_on,
  output logic              mb_en,
  output logic              port_gate
);
  asd_pkg::asd_hit_t hit;
  logic gen_we, wake_we, mb_we, rd_gen, rd_wake, setup_next;
  logic unused_wdata;

  asd_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr (io_addr),
    .hit  (hit)
  );

  assign gen_we  = io_wr && hit.gen;
  assign wake_we = io_wr && hit.wake && setup_mode;
  assign mb_we   = io_wr && hit.mb && !setup_mode;
  assign rd_gen  = io_rd && hit.gen && rd_enable_ctl;
  assign rd_wake = io_rd && hit.wake && setup_mode;
  assign unused_wdata = ^io_wdata[DATA_W-1:PAGE_W+2];

  asd_state_regs #(.PAGE_W(PAGE_W)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .gen_we     (gen_we),
    .wake_we    (wake_we),
    .mb_we      (mb_we),
    .gen_wdata  (io_wdata[PAGE_W+1:0]),
    .bit0       (io_wdata[0]),
    .rom_page   (rom_page),
    .adapter_en (adapter_en),
    .setup_mode (setup_mode),
    .setup_next (setup_next),
    .display_on (display_on),
    .mb_en      (mb_en)
  );

  asd_response #(.DATA_W(DATA_W), .PAGE_W(PAGE_W)) u_resp (
    .clk        (clk),
    .rst        (rst),
    .claim_wr   (gen_we | wake_we | mb_we),
    .rd_gen     (rd_gen),
    .rd_wake    (rd_wake),
    .rom_page   (rom_page),
    .adapter_en (adapter_en),
    .setup_mode (setup_mode),
    .display_on (display_on),
    .io_rdata   (io_rdata),
    .io_claim   (io_claim)
  );

  assign port_gate = !setup_next;
endmodule

// File: rtl/asd_checker.sv
module asd_checker (
  input logic        clk,
  input logic        rst,
  input logic [15:0] io_addr,
  input logic        io_rd,
  input logic        io_wr,
  input logic        rd_enable_ctl,
  input logic [7:0]  io_rdata,
  input logic        io_claim,
  input logic        setup_mode,
  input logic        mb_en,
  input logic        display_on,
  input logic        port_gate
);
  // R6: setup mode never comes up without the gate having dropped first
  p_gate_drop_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(setup_mode) |-> $past(!port_gate));

  // R3: a claim always follows a strobe
  p_claim_follows_r3: assert property (@(posedge clk) disable iff (rst)
    io_claim |-> $past(io_rd || io_wr));

  // R3: a read without read enable at the enable port is never claimed
  p_gen_read_gate_r3: assert property (@(posedge clk) disable iff (rst)
    (io_claim && !$past(rd_enable_ctl)) |-> !$past(io_rd && io_addr[11:0] == 12'h6E8));

  // R4: wake port claims only while in setup
  p_wake_setup_r4: assert property (@(posedge clk) disable iff (rst)
    (io_claim && $past(io_addr == 16'h0102)) |-> $past(setup_mode));

  // R4: display_on holds outside setup mode
  p_wake_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !$past(setup_mode) |-> $stable(display_on));

  // R5: motherboard flag holds while in setup mode
  p_mb_hold_r5: assert property (@(posedge clk) disable iff (rst)
    $past(setup_mode) |-> $stable(mb_en));

  // R2: reserved read bits are zero
  p_reserved_zero_r2: assert property (@(posedge clk) disable iff (rst)
    io_claim |-> io_rdata[7:5] == 3'b000);
endmodule

bind adapter_setup_decoder asd_checker i_chk (
  .clk           (clk),
  .rst           (rst),
  .io_addr       (io_addr),
  .io_rd         (io_rd),
  .io_wr         (io_wr),
  .rd_enable_ctl (rd_enable_ctl),
  .io_rdata      (io_rdata),
  .io_claim      (io_claim),
  .setup_mode    (setup_mode),
  .mb_en         (mb_en),
  .display_on    (display_on),
  .port_gate     (port_gate)
);

// File: tb/test_adapter_setup_decoder.sv
module test_adapter_setup_decoder;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] io_addr = '0;
  logic        io_rd = 1'b0, io_wr = 1'b0;
  logic [7:0]  io_wdata = '0;
  logic        rd_enable_ctl = 1'b0;
  logic [7:0]  io_rdata;
  logic        io_claim, adapter_en, setup_mode, display_on, mb_en, port_gate;
  logic [2:0]  rom_page;

  int tests = 0, fails = 0;

  always #10 clk = ~clk;

  adapter_setup_decoder i_adapter_setup_decoder (
    .clk(clk), .rst(rst), .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr),
    .io_wdata(io_wdata), .rd_enable_ctl(rd_enable_ctl), .io_rdata(io_rdata),
    .io_claim(io_claim), .adapter_en(adapter_en), .setup_mode(setup_mode),
    .rom_page(rom_page), .display_on(display_on), .mb_en(mb_en),
    .port_gate(port_gate)
  );

  // vector: rd(1) addr(16) wdata(8) rden(1) exp_claim(1) exp_rdata(8) = 35 bits
  localparam int NV = 19;
  localparam logic [34:0] VEC [NV] = '{
    {1'b1, 16'h46E8, 8'h00, 1'b1, 1'b1, 8'h00}, // R3 read after reset
    {1'b0, 16'h46E8, 8'hE5, 1'b0, 1'b1, 8'h00}, // R2 write, reserved set
    {1'b1, 16'h56E8, 8'h00, 1'b1, 1'b1, 8'h05}, // R2 alias, reserved dropped
    {1'b0, 16'h66E8, 8'h0A, 1'b0, 1'b1, 8'h00}, // R2 alias write
    {1'b1, 16'h76E8, 8'h00, 1'b0, 1'b0, 8'h00}, // R3 read blocked
    {1'b1, 16'h76E8, 8'h00, 1'b1, 1'b1, 8'h0A}, // R3 read allowed
    {1'b1, 16'h0102, 8'h00, 1'b1, 1'b0, 8'h00}, // R4 wake silent
    {1'b0, 16'h0102, 8'h01, 1'b0, 1'b0, 8'h00}, // R4 wake write ignored
    {1'b0, 16'h03C3, 8'h01, 1'b0, 1'b1, 8'h00}, // R5 mb write
    {1'b1, 16'h03C3, 8'h00, 1'b1, 1'b0, 8'h00}, // R5 mb read unclaimed
    {1'b0, 16'h86E8, 8'h1F, 1'b0, 1'b0, 8'h00}, // R8 non-alias
    {1'b1, 16'h46E9, 8'h00, 1'b1, 1'b0, 8'h00}, // R8 near miss
    {1'b0, 16'h46E8, 8'h1A, 1'b0, 1'b1, 8'h00}, // R2 enter setup
    {1'b0, 16'h03C3, 8'h00, 1'b0, 1'b0, 8'h00}, // R5 ignored in setup
    {1'b0, 16'h0102, 8'hFF, 1'b0, 1'b1, 8'h00}, // R4 wake write
    {1'b1, 16'h0102, 8'h00, 1'b0, 1'b1, 8'h01}, // R4 wake read
    {1'b1, 16'h46E8, 8'h00, 1'b1, 1'b1, 8'h1A}, // R7 enable read in setup
    {1'b0, 16'h46E8, 8'h0A, 1'b0, 1'b1, 8'h00}, // R7 leave setup
    {1'b1, 16'h0102, 8'h00, 1'b1, 1'b0, 8'h00}  // R4 silent again
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic access(input logic rd, input logic [15:0] a, input logic [7:0] d,
                        input logic en);
    @(negedge clk);
    io_addr = a; io_wdata = d; rd_enable_ctl = en; io_rd = rd; io_wr = !rd;
    @(negedge clk);
    io_rd = 1'b0; io_wr = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 setup", {31'b0, setup_mode}, 0);
    check("R1 gate", {31'b0, port_gate}, 1);
    rst = 1'b0;
    @(negedge clk);
    check("R1 flags", {26'b0, adapter_en, rom_page, display_on, mb_en}, 0);
    check("R1 claim", {31'b0, io_claim}, 0);

    for (int i = 0; i < NV; i++) begin
      access(VEC[i][34], VEC[i][33:18], VEC[i][17:10], VEC[i][9]);
      check($sformatf("R3 claim vec %0d", i), {31'b0, io_claim}, {31'b0, VEC[i][8]});
      check($sformatf("R3 rdata vec %0d", i), {24'b0, io_rdata}, {24'b0, VEC[i][7:0]});
    end

    check("R2 page", {29'b0, rom_page}, 2);
    check("R2 adapter_en", {31'b0, adapter_en}, 1);
    check("R4 display_on kept", {31'b0, display_on}, 1);
    check("R5 mb_en kept", {31'b0, mb_en}, 1);
    @(negedge clk);
    check("R3 claim one cycle", {31'b0, io_claim}, 0);

    // R6: same-cycle gate
    io_addr = 16'h56E8; io_wdata = 8'h10; io_wr = 1'b1;
    #2;
    check("R6 gate drops before edge", {31'b0, port_gate}, 0);
    check("R6 setup still clear", {31'b0, setup_mode}, 0);
    @(negedge clk);
    io_wr = 1'b0;
    #2;
    check("R6 gate low in setup", {31'b0, port_gate}, 0);
    @(negedge clk);
    io_addr = 16'h76E8; io_wdata = 8'h00; io_wr = 1'b1;
    #2;
    check("R6 gate rises before edge", {31'b0, port_gate}, 1);
    @(negedge clk);
    io_wr = 1'b0;
    check("R6 setup cleared", {31'b0, setup_mode}, 0);

    // R1: reset mid-run
    access(1'b0, 16'h46E8, 8'h1F, 1'b0);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R1 reset clears", {26'b0, setup_mode, adapter_en, rom_page, display_on}, 0);
    check("R1 reset gate", {31'b0, port_gate}, 1);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule